// File: doc/BRIEF.md
# Boundary Scan Cell Chain

This block is a row of identical test cells that sits between a device's input pads and the core logic they feed. Each cell has two storage stages. The first stage either captures the value arriving from the pad or takes the bit from its upstream neighbour, so the row behaves as a serial shift path. The second stage holds a copy of the first stage. That copy is refreshed only by an explicit update strobe, so bits moving through the shift path never reach the core while they are in transit.

A single test clock drives both stages. The capture/shift stage acts on the rising edge while its enable is high. The hold stage acts on the falling edge while the update enable is high. A mode select picks what each core-side output carries: the live pad value in functional operation, or the held test value in test operation. A test controller outside the block drives the four control lines. Serial data enters at the cell nearest the chain input and leaves from the capture stage of the far end.

Top module: `bscan_chain`

## Requirements
- R1: A synchronous active-high reset clears every capture stage on the rising clock edge and every hold stage on the falling clock edge, so that after reset the serial output is 0 and, in test mode, every core-side output is 0.
- R2: With the mode select at 0, each core-side output equals its pad input combinationally, whatever the shift, capture and update controls are doing.
- R3: On a rising edge with the capture enable at 1 and the shift select at 0, every capture stage loads its own pad input.
- R4: On a rising edge with the capture enable at 1 and the shift select at 1, cell 0 loads the serial input, each cell i loads the capture stage of cell i-1, and the serial output always shows the capture stage of cell N-1.
- R5: On a rising edge with the capture enable at 0, no capture stage changes. The serial output is observed to stay the same.
- R6: On a falling edge with the update enable at 1, every hold stage copies its capture stage. With the update enable at 0, the hold stages keep their value.
- R7: With the mode select at 1, each core-side output shows its hold stage, so shifting alone leaves the core-side outputs unchanged until an update.
- R8: Shifting N bits in (the bit meant for cell N-1 first), then one update with the mode select at 1, drives exactly that pattern onto the core-side outputs, with bit i on output i.
- R9: A capture followed by shifts presents the captured pad values on the serial output in order from cell N-1 down to cell 0. The first of them is visible right after the capture.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock; capture/shift on rising edge, update on falling edge |
| rst | input | 1 | Synchronous active-high reset of both stages |
| shift_sel | input | 1 | 1 selects the serial neighbour, 0 selects the pad value |
| cap_en | input | 1 | Enables the capture/shift stage on the rising edge |
| upd_en | input | 1 | Enables the hold stage on the falling edge |
| test_mode | input | 1 | 0 passes pad values to the core, 1 drives the held test values |
| pad_in | input | N | Pad-side inputs, one per cell |
| scan_in | input | 1 | Serial input into cell 0 |
| core_out | output | N | Core-side outputs, one per cell |
| scan_out | output | 1 | Serial output, the capture stage of cell N-1 |

## Verification
The bench targets the point where capture and update share a clock period. The update on the falling edge must take the capture stage as it stood before the next rising edge. A design that clocked both stages on one edge would copy the wrong, already shifted value. Long runs of shifting in test mode with no update expose a design that leaks the shift path onto the core outputs. A reversed chain direction would show up as a mirrored pattern in the full-width load and in the serial readout of a captured word. Functional-mode passes under random control traffic catch an output multiplexer that selects on the wrong control line.

// File: rtl/bsc_pkg.sv
package bsc_pkg;

    // Shared control bundle delivered to every cell of the chain
    typedef struct packed {
        logic shift_sel;
        logic cap_en;
        logic upd_en;
        logic test_mode;
    } bsc_ctrl_t;

    // Selects the value the capture stage loads
    function automatic logic capture_src(input logic sel, input logic serial_bit,
                                         input logic pad_bit);
        return sel ? serial_bit : pad_bit;
    endfunction

    // Selects what the core side sees
    function automatic logic core_src(input logic test_sel, input logic held_bit,
                                      input logic pad_bit);
        return test_sel ? held_bit : pad_bit;
    endfunction

endpackage

// File: rtl/bsc_capture_stage.sv
module bsc_capture_stage
    import bsc_pkg::*;
(
    input  logic      tck,
    input  logic      rst,
    input  bsc_ctrl_t ctrl,
    input  logic      pad_bit,
    input  logic      serial_bit,
    output logic      q
);

    always_ff @(posedge tck) begin
        if (rst) begin
            q <= 1'b0;
        end else if (ctrl.cap_en) begin
            q <= capture_src(ctrl.shift_sel, serial_bit, pad_bit);
        end
    end

endmodule

// File: rtl/bsc_update_stage.sv
module bsc_update_stage
    import bsc_pkg::*;
(
    input  logic      tck,
    input  logic      rst,
    input  bsc_ctrl_t ctrl,
    input  logic      d,
    output logic      q
);

    // Falling-edge stage keeps the pin value steady while the rising-edge path shifts
    always_ff @(negedge tck) begin
        if (rst) begin
            q <= 1'b0;
        end else if (ctrl.upd_en) begin
            q <= d;
        end
    end

endmodule

// File: rtl/bsc_cell.sv
module bsc_cell
    import bsc_pkg::*;
(
    input  logic      tck,
    input  logic      rst,
    input  bsc_ctrl_t ctrl,
    input  logic      pad_bit,
    input  logic      serial_in,
    output logic      serial_out,
    output logic      hold_bit,
    output logic      core_bit
);

    logic cap_q;

    bsc_capture_stage u_cap (
        .tck        (tck),
        .rst        (rst),
        .ctrl       (ctrl),
        .pad_bit    (pad_bit),
        .serial_bit (serial_in),
        .q          (cap_q)
    );

    bsc_update_stage u_upd (
        .tck  (tck),
        .rst  (rst),
        .ctrl (ctrl),
        .d    (cap_q),
        .q    (hold_bit)
    );

    assign serial_out = cap_q;

    always_comb begin
        core_bit = core_src(ctrl.test_mode, hold_bit, pad_bit);
    end

endmodule

// File: rtl/bscan_chain.sv
module bscan_chain
    import bsc_pkg::*;
#(
    parameter int N = 8
) (
    input  logic         tck,
    input  logic         rst,
    input  logic         shift_sel,
    input  logic         cap_en,
    input  logic         upd_en,
    input  logic         test_mode,
    input  logic [N-1:0] pad_in,
    input  logic         scan_in,
    output logic [N-1:0] core_out,
    output logic         scan_out
);

    localparam int LINKS = N + 1;

    bsc_ctrl_t        ctrl;
    logic [LINKS-1:0] link;
    logic [N-1:0]     stage_q;
    logic [N-1:0]     hold_q;

    always_comb begin
        ctrl.shift_sel = shift_sel;
        ctrl.cap_en    = cap_en;
        ctrl.upd_en    = upd_en;
        ctrl.test_mode = test_mode;
    end

    assign link[0] = scan_in;

    for (genvar i = 0; i < N; i++) begin : g_cell
        bsc_cell u_cell (
            .tck        (tck),
            .rst        (rst),
            .ctrl       (ctrl),
            .pad_bit    (pad_in[i]),
            .serial_in  (link[i]),
            .serial_out (link[i+1]),
            .hold_bit   (hold_q[i]),
            .core_bit   (core_out[i])
        );
        assign stage_q[i] = link[i+1];
    end

    assign scan_out = link[N];

endmodule

// File: rtl/bscan_chain_chk.sv
module bscan_chain_chk #(
    parameter int N = 8
) (
    input logic         tck,
    input logic         rst,
    input logic         shift_sel,
    input logic         cap_en,
    input logic         upd_en,
    input logic         test_mode,
    input logic [N-1:0] pad_in,
    input logic         scan_in,
    input logic [N-1:0] core_out,
    input logic         scan_out,
    input logic [N-1:0] stage_q,
    input logic [N-1:0] hold_q
);

    // R2: functional mode passes pads straight through
    p_func_pass_r2: assert property (@(posedge tck) disable iff (rst)
        !test_mode |-> core_out == pad_in);

    // R3: capture loads the pads
    p_capture_r3: assert property (@(posedge tck) disable iff (rst)
        cap_en && !shift_sel |=> stage_q == $past(pad_in));

    // R4: shift moves toward the far end
    p_shift_head_r4: assert property (@(posedge tck) disable iff (rst)
        cap_en && shift_sel |=> stage_q[0] == $past(scan_in));

    p_shift_body_r4: assert property (@(posedge tck) disable iff (rst)
        cap_en && shift_sel |=> stage_q[N-1:1] == $past(stage_q[N-2:0]));

    // R5: serial output quiet without capture enable
    p_quiet_r5: assert property (@(posedge tck) disable iff (rst)
        !cap_en |=> $stable(scan_out));

    // R6: hold stage copies or keeps on the falling edge
    p_update_r6: assert property (@(negedge tck) disable iff (rst)
        upd_en |=> hold_q == $past(stage_q));

    p_keep_r6: assert property (@(negedge tck) disable iff (rst)
        !upd_en |=> $stable(hold_q));

    // R7: test mode shows the held value
    p_test_drive_r7: assert property (@(posedge tck) disable iff (rst)
        test_mode |-> core_out == hold_q);

endmodule

bind bscan_chain bscan_chain_chk #(.N(N)) u_chk (
    .tck       (tck),
    .rst       (rst),
    .shift_sel (shift_sel),
    .cap_en    (cap_en),
    .upd_en    (upd_en),
    .test_mode (test_mode),
    .pad_in    (pad_in),
    .scan_in   (scan_in),
    .core_out  (core_out),
    .scan_out  (scan_out),
    .stage_q   (stage_q),
    .hold_q    (hold_q)
);

// File: tb/sim_bscan_chain.sv
module sim_bscan_chain;

    localparam int N      = 8;
    localparam int CLK_NS = 10;

    logic         tck = 1'b0;
    logic         rst;
    logic         shift_sel, cap_en, upd_en, test_mode, scan_in;
    logic [N-1:0] pad_in;
    logic [N-1:0] core_out;
    logic         scan_out;

    int tests = 0;
    int fails = 0;

    logic [N-1:0] m_cap, m_hold;

    bscan_chain #(.N(N)) u0 (
        .tck(tck), .rst(rst), .shift_sel(shift_sel), .cap_en(cap_en),
        .upd_en(upd_en), .test_mode(test_mode), .pad_in(pad_in),
        .scan_in(scan_in), .core_out(core_out), .scan_out(scan_out)
    );

    always #(CLK_NS/2) tck = ~tck;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected model: falling-edge update sees the capture stage before the next rising edge
    function automatic logic [N-1:0] next_cap(input logic [N-1:0] cur, input logic ce,
                                              input logic ss, input logic si,
                                              input logic [N-1:0] pin);
        if (!ce) return cur;
        if (ss)  return {cur[N-2:0], si};
        return pin;
    endfunction

    task automatic step(input logic ce, input logic ss, input logic ue, input logic tm,
                        input logic [N-1:0] pin, input logic si);
        cap_en = ce; shift_sel = ss; upd_en = ue; test_mode = tm;
        pad_in = pin; scan_in = si;
        @(posedge tck); #2;
        if (rst) begin
            m_cap = '0; m_hold = '0;
        end else begin
            if (ue) m_hold = m_cap;
            m_cap = next_cap(m_cap, ce, ss, si, pin);
        end
        check(ce ? (ss ? "R4 shift" : "R3 capture") : "R5 hold", 32'(scan_out), 32'(m_cap[N-1]));
        check(tm ? (ue ? "R6 update" : "R7 test drive") : "R2 pass", 32'(core_out),
              32'(tm ? m_hold : pin));
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge tck);
        fails++;
        $display("FAIL watchdog expired actual=%h expected=%h", 1, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [N-1:0] pat;
        void'($urandom(32'h5eed));
        rst = 1'b1;
        cap_en = 0; shift_sel = 0; upd_en = 0; test_mode = 0; pad_in = '0; scan_in = 0;
        m_cap = '0; m_hold = '0;
        @(posedge tck); #2;
        step(1, 1, 1, 1, 8'hFF, 1);
        step(0, 0, 0, 1, 8'hFF, 1);
        rst = 1'b0;
        step(0, 0, 0, 1, 8'h5A, 0);
        check("R1 reset serial", 32'(scan_out), 32'h0);
        check("R1 reset core", 32'(core_out), 32'h0);

        // R8: full-width load, far-end bit first
        pat = 8'hB4;
        for (int k = N - 1; k >= 0; k--) step(1, 1, 0, 1, 8'h3C, pat[k]);
        check("R7 no leak before update", 32'(core_out), 32'h0);
        step(0, 0, 1, 1, 8'h3C, 0);
        check("R8 loaded pattern", 32'(core_out), 32'(pat));
        step(0, 0, 0, 0, 8'hC3, 0);
        check("R2 functional mode", 32'(core_out), 32'hC3);

        // R9: capture then serial readout from cell N-1 down
        pat = 8'h6D;
        step(1, 0, 0, 0, pat, 0);
        check("R9 first readout bit", 32'(scan_out), 32'(pat[N-1]));
        for (int k = N - 2; k >= 0; k--) begin
            step(1, 1, 0, 0, 8'h00, 1);
            check("R9 readout bit", 32'(scan_out), 32'(pat[k]));
        end

        // R5/R6: idle cycles change nothing
        step(0, 1, 0, 1, 8'hFF, 0);
        check("R6 hold kept", 32'(core_out), 32'hB4);

        // Constrained random traffic
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] r;
            r = $urandom;
            step(r[0] | r[1], r[2] | r[3], r[4] & r[5], r[6] | r[7],
                 N'($urandom), r[8]);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule